// File: doc/BRIEF.md
# Peripheral I/O Chip-Select Decoder

This block turns a 16-bit I/O-space address and its read and write strobes into chip-selects for six legacy peripheral functions: two serial ports (A and B), a parallel port, an IDE command block, an IDE control port and a floppy controller. It also reports which interrupt line each serial and parallel function is wired to, and raises a flag when two character-device functions claim the same address. Two configuration words drive the placement. The port word places the serial and parallel functions. The disk word enables the IDE and floppy functions and moves them together between a primary and an alternate set of bases.

Each function has a small encoded field. A field value either picks one of a few fixed legacy bases or disables the function. The decode result is captured in one register stage, so every output follows its inputs by exactly one clock. A system bus controller feeds the address and strobes in. It feeds the configuration words in from its register bank, and it uses the registered chip-selects to steer the access.

Top module: `pio_select_decoder`

## Requirements
- R1: Port word bits [3:1] place serial B. Code 1 places it at 0x3F8, 2 at 0x2F8, 3 at 0x3E8 and 4 at 0x2E8, and it decodes 8 bytes from that base. Codes 0, 5, 6 and 7 disable it. Its IRQ output reads 3 while it is placed and 0 while it is disabled.
- R2: Port word bits [7:5] place serial A, using the same code-to-base mapping and the same 8-byte window as R1. Its IRQ output reads 4 while it is placed and 0 while it is disabled.
- R3: Port word bits [10:9] place the parallel port. Code 1 places it at 0x3BC with a 4-byte window. Code 2 places it at 0x378 and code 3 at 0x278, each with an 8-byte window. Code 0 disables it. Its IRQ output reads 7 while it is placed and 0 while it is disabled.
- R4: The IDE command block (8 bytes) and the IDE control port (1 byte) are enabled while disk word bit 0 is 0. They are disabled while that bit is 1.
- R5: Disk word bit 4 selects the base set. When it is 0, IDE command is at 0x1F0, IDE control at 0x3F6 and the floppy at 0x3F0. When it is 1, these are 0x170, 0x376 and 0x370.
- R6: The floppy controller (8 bytes) is enabled only while disk word bit 1 is 0. While IDE is enabled, the IDE control byte inside the floppy window selects only IDE control, and no conflict is raised.
- R7: No chip-select and no conflict asserts unless io_rd or io_wr is 1.
- R8: When more than one of serial A, serial B and parallel matches, serial A wins over serial B, serial B wins over parallel, and conflict_o is 1.
- R9: Every output shows the decode of the inputs from the previous clock edge. While rst_n is 0, all outputs are 0.
- R10: sel_o has at most one bit set. Bit 0 is serial A, 1 is serial B, 2 is parallel, 3 is IDE command, 4 is IDE control and 5 is floppy.
- R11: A match needs every address bit above the window to equal the base. For example, 0x13F8 selects nothing.
- R12: Port word bits 0, 4, 8 and 11 to 15, and disk word bits other than 0, 1 and 4, have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | ADDR_W (16) | I/O address |
| io_rd | input | 1 | Read strobe, active high |
| io_wr | input | 1 | Write strobe, active high |
| port_cfg | input | 16 | Serial and parallel placement word |
| disk_cfg | input | 16 | IDE and floppy enable and base-set word |
| sel_o | output | 6 | Registered chip-selects, at most one set |
| irq_ser_a_o | output | IRQ_W (4) | IRQ number of serial A, 0 when disabled |
| irq_ser_b_o | output | IRQ_W (4) | IRQ number of serial B, 0 when disabled |
| irq_par_o | output | IRQ_W (4) | IRQ number of the parallel port, 0 when disabled |
| conflict_o | output | 1 | Registered overlap flag among serial A, serial B and parallel |

## Verification
A wrong base, window size or enable shows up as a missing or extra chip-select bit exactly one clock after the access is presented. The bench therefore sweeps every field code against addresses at each window's first byte, last byte and first byte past the end. A broken priority or overlap rule shows up in the same cycle as two set bits in sel_o, or as a wrong conflict_o, when both serial ports are given the same code. A bad IRQ mapping shows up on the IRQ outputs one clock after the port word changes.

// File: rtl/pio_sel_pkg.sv
package pio_sel_pkg;

   localparam int unsigned CFG_W = 16;
   localparam int unsigned NFUNC = 6;

   // chip-select bit positions; the order is the priority order of the arbiter
   localparam int unsigned FN_SER_A   = 0;
   localparam int unsigned FN_SER_B   = 1;
   localparam int unsigned FN_PAR     = 2;
   localparam int unsigned FN_IDE_CMD = 3;
   localparam int unsigned FN_IDE_CTL = 4;
   localparam int unsigned FN_FDC     = 5;

   typedef struct packed {
      logic        en;
      logic [15:0] base;
   } slot_t;

   // serial placement code to legacy base
   function automatic slot_t serial_slot(input logic [2:0] code);
      slot_t s;
      s.en = 1'b1;
      case (code)
         3'd1:    s.base = 16'h03F8;
         3'd2:    s.base = 16'h02F8;
         3'd3:    s.base = 16'h03E8;
         3'd4:    s.base = 16'h02E8;
         default: begin s.en = 1'b0; s.base = 16'h0000; end
      endcase
      return s;
   endfunction

   // parallel placement code to legacy base
   function automatic slot_t parallel_slot(input logic [1:0] code);
      slot_t s;
      s.en = 1'b1;
      case (code)
         2'd1:    s.base = 16'h03BC;
         2'd2:    s.base = 16'h0378;
         2'd3:    s.base = 16'h0278;
         default: begin s.en = 1'b0; s.base = 16'h0000; end
      endcase
      return s;
   endfunction

   // window size of each function, log2 of bytes
   function automatic int unsigned wide_log2(input int unsigned fn);
      return (fn == FN_IDE_CTL) ? 0 : 3;
   endfunction

   function automatic int unsigned narrow_log2(input int unsigned fn);
      return (fn == FN_PAR) ? 2 : wide_log2(fn);
   endfunction

endpackage

// File: rtl/pio_port_map.sv
module pio_port_map
   import pio_sel_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  logic [CFG_W-1:0]             port_cfg,
   input  logic [CFG_W-1:0]             disk_cfg,
   output logic [NFUNC-1:0]             fn_en,
   output logic [NFUNC-1:0][ADDR_W-1:0] fn_base,
   output logic                         par_narrow
);

   // serial field positions: slot 0 is serial A, slot 1 is serial B
   localparam int unsigned SER_LSB_A = 5;
   localparam int unsigned SER_LSB_B = 1;

   genvar g;
   generate
      for (g = 0; g < 2; g++) begin : g_ser
         localparam int unsigned LSB = (g == 0) ? SER_LSB_A : SER_LSB_B;
         localparam int unsigned FN  = (g == 0) ? FN_SER_A : FN_SER_B;
         slot_t s;
         always_comb s = serial_slot(port_cfg[LSB+2:LSB]);
         assign fn_en[FN]   = s.en;
         assign fn_base[FN] = ADDR_W'(s.base);
      end
   endgenerate

   slot_t par_s;
   always_comb par_s = parallel_slot(port_cfg[10:9]);
   assign fn_en[FN_PAR]   = par_s.en;
   assign fn_base[FN_PAR] = ADDR_W'(par_s.base);
   assign par_narrow      = (port_cfg[10:9] == 2'd1);

   logic alt_set;
   logic ide_on;
   logic fdc_on;
   assign alt_set = disk_cfg[4];
   assign ide_on  = ~disk_cfg[0];
   assign fdc_on  = ~disk_cfg[1];

   assign fn_en[FN_IDE_CMD]   = ide_on;
   assign fn_en[FN_IDE_CTL]   = ide_on;
   assign fn_en[FN_FDC]       = fdc_on;
   assign fn_base[FN_IDE_CMD] = ADDR_W'(alt_set ? 16'h0170 : 16'h01F0);
   assign fn_base[FN_IDE_CTL] = ADDR_W'(alt_set ? 16'h0376 : 16'h03F6);
   assign fn_base[FN_FDC]     = ADDR_W'(alt_set ? 16'h0370 : 16'h03F0);

   // fields with no function in this block (R12)
   logic unused_cfg_bits;
   assign unused_cfg_bits = ^{port_cfg[15:11], port_cfg[8], port_cfg[4], port_cfg[0],
                              disk_cfg[15:5], disk_cfg[3:2]};

endmodule

// File: rtl/pio_window.sv
module pio_window #(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned WIDE_LOG2   = 3,
   parameter int unsigned NARROW_LOG2 = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic              en,
   input  logic              narrow,
   output logic              hit
);

   localparam logic [ADDR_W-1:0] WIDE_MASK   = ~((ADDR_W'(1) << WIDE_LOG2) - ADDR_W'(1));
   localparam logic [ADDR_W-1:0] NARROW_MASK = ~((ADDR_W'(1) << NARROW_LOG2) - ADDR_W'(1));

   generate
      if (WIDE_LOG2 >= ADDR_W || NARROW_LOG2 >= ADDR_W) begin : g_bad_span
         $error("pio_window: window span must be narrower than the address");
      end
   endgenerate

   logic [ADDR_W-1:0] mask;
   assign mask = narrow ? NARROW_MASK : WIDE_MASK;
   assign hit  = en && (((addr ^ base) & mask) == '0);

endmodule

// File: rtl/pio_sel_arbiter.sv
module pio_sel_arbiter
   import pio_sel_pkg::*;
(
   input  logic [NFUNC-1:0] raw_hit,
   input  logic             strobe,
   output logic [NFUNC-1:0] sel,
   output logic             conflict
);

   logic [NFUNC-1:0] h;
   assign h = strobe ? raw_hit : '0;

   always_comb begin
      sel             = '0;
      sel[FN_SER_A]   = h[FN_SER_A];
      sel[FN_SER_B]   = h[FN_SER_B] & ~h[FN_SER_A];
      sel[FN_PAR]     = h[FN_PAR] & ~h[FN_SER_A] & ~h[FN_SER_B];
      sel[FN_IDE_CMD] = h[FN_IDE_CMD];
      sel[FN_IDE_CTL] = h[FN_IDE_CTL];
      sel[FN_FDC]     = h[FN_FDC] & ~h[FN_IDE_CTL];
   end

   assign conflict = (h[FN_SER_A] & h[FN_SER_B]) |
                     (h[FN_SER_A] & h[FN_PAR])   |
                     (h[FN_SER_B] & h[FN_PAR]);

endmodule

// File: rtl/pio_select_decoder.sv
module pio_select_decoder
   import pio_sel_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned IRQ_W     = 4,
   parameter int unsigned IRQ_SER_A = 4,
   parameter int unsigned IRQ_SER_B = 3,
   parameter int unsigned IRQ_PAR   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [15:0]       port_cfg,
   input  logic [15:0]       disk_cfg,
   output logic [5:0]        sel_o,
   output logic [IRQ_W-1:0]  irq_ser_a_o,
   output logic [IRQ_W-1:0]  irq_ser_b_o,
   output logic [IRQ_W-1:0]  irq_par_o,
   output logic              conflict_o
);

   localparam int unsigned IRQ_LIMIT = 1 << IRQ_W;

   generate
      if (ADDR_W < 16) begin : g_bad_addr
         $error("pio_select_decoder: ADDR_W must hold a 16-bit I/O address");
      end
      if (IRQ_SER_A >= IRQ_LIMIT || IRQ_SER_B >= IRQ_LIMIT || IRQ_PAR >= IRQ_LIMIT) begin : g_bad_irq
         $error("pio_select_decoder: IRQ numbers must fit in IRQ_W bits");
      end
      if (NFUNC != 6) begin : g_bad_nfunc
         $error("pio_select_decoder: chip-select vector is six functions wide");
      end
   endgenerate

   logic [NFUNC-1:0]             fn_en;
   logic [NFUNC-1:0][ADDR_W-1:0] fn_base;
   logic                         par_narrow;

   pio_port_map #(.ADDR_W(ADDR_W)) u_map (
      .port_cfg  (port_cfg),
      .disk_cfg  (disk_cfg),
      .fn_en     (fn_en),
      .fn_base   (fn_base),
      .par_narrow(par_narrow)
   );

   logic [NFUNC-1:0] raw_hit;

   genvar f;
   generate
      for (f = 0; f < NFUNC; f++) begin : g_win
         pio_window #(
            .ADDR_W     (ADDR_W),
            .WIDE_LOG2  (wide_log2(f)),
            .NARROW_LOG2(narrow_log2(f))
         ) u_win (
            .addr  (io_addr),
            .base  (fn_base[f]),
            .en    (fn_en[f]),
            .narrow((f == FN_PAR) ? par_narrow : 1'b0),
            .hit   (raw_hit[f])
         );
      end
   endgenerate

   logic [NFUNC-1:0] sel_d;
   logic             conflict_d;

   pio_sel_arbiter u_arb (
      .raw_hit (raw_hit),
      .strobe  (io_rd | io_wr),
      .sel     (sel_d),
      .conflict(conflict_d)
   );

   // registered output stage, one cycle of decode latency
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_o       <= '0;
         conflict_o  <= 1'b0;
         irq_ser_a_o <= '0;
         irq_ser_b_o <= '0;
         irq_par_o   <= '0;
      end else begin
         sel_o       <= sel_d;
         conflict_o  <= conflict_d;
         irq_ser_a_o <= fn_en[FN_SER_A] ? IRQ_W'(IRQ_SER_A) : '0;
         irq_ser_b_o <= fn_en[FN_SER_B] ? IRQ_W'(IRQ_SER_B) : '0;
         irq_par_o   <= fn_en[FN_PAR]   ? IRQ_W'(IRQ_PAR)   : '0;
      end
   end

   assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_o));

   assert_strobe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_rd || io_wr) |=> (sel_o == '0) && !conflict_o);

   assert_conflict_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
      conflict_o |-> (sel_o[FN_SER_A] || sel_o[FN_SER_B]));

   assert_ser_b_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ser_b_o == '0) || (irq_ser_b_o == IRQ_W'(IRQ_SER_B)));

   assert_ide_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o[FN_IDE_CMD] || sel_o[FN_IDE_CTL]) |-> !$past(disk_cfg[0]));

   assert_fdc_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sel_o[FN_FDC] |-> !$past(disk_cfg[1]));

   assert_par_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_o[FN_PAR] |-> ($past(port_cfg[10:9]) != 2'd0));

endmodule

// File: tb/sim_pio_select_decoder.sv
module sim_pio_select_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = 16'h03F8;
   logic        io_rd = 1'b1;
   logic        io_wr = 1'b0;
   logic [15:0] port_cfg = 16'h0222;
   logic [15:0] disk_cfg = 16'h0000;
   logic [5:0]  sel_o;
   logic [3:0]  irq_ser_a_o, irq_ser_b_o, irq_par_o;
   logic        conflict_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   pio_select_decoder u0 (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .port_cfg(port_cfg), .disk_cfg(disk_cfg), .sel_o(sel_o),
      .irq_ser_a_o(irq_ser_a_o), .irq_ser_b_o(irq_ser_b_o), .irq_par_o(irq_par_o),
      .conflict_o(conflict_o)
   );

   typedef struct {
      logic [5:0] sel;
      logic       cf;
      logic [3:0] ia;
      logic [3:0] ib;
      logic [3:0] ip;
      int         req;
   } exp_t;

   exp_t sb[$];

   // ---------------- reference model, written from the requirements ----------
   function automatic bit in_win(input logic [15:0] a, input logic [15:0] b, input int span);
      return (a >= b) && (a < b + 16'(span));
   endfunction

   function automatic logic [16:0] ser_place(input logic [2:0] c); // {en, base}
      case (c)
         3'd1: return {1'b1, 16'h03F8};
         3'd2: return {1'b1, 16'h02F8};
         3'd3: return {1'b1, 16'h03E8};
         3'd4: return {1'b1, 16'h02E8};
         default: return 17'd0;
      endcase
   endfunction

   function automatic exp_t model(input logic [15:0] a, input logic st,
                                  input logic [15:0] pw, input logic [15:0] dw, input int req);
      exp_t e;
      logic [16:0] sa, sbp;
      bit ha, hb, hp, hic, hik, hf;
      logic [15:0] pb; int ps; bit pen;
      sa  = ser_place(pw[7:5]);   // R2
      sbp = ser_place(pw[3:1]);   // R1
      pen = 1'b1; ps = 8;
      case (pw[10:9])             // R3
         2'd1: begin pb = 16'h03BC; ps = 4; end
         2'd2: pb = 16'h0378;
         2'd3: pb = 16'h0278;
         default: begin pb = 16'h0; pen = 1'b0; end
      endcase
      ha  = st && sa[16]  && in_win(a, sa[15:0], 8);
      hb  = st && sbp[16] && in_win(a, sbp[15:0], 8);
      hp  = st && pen && in_win(a, pb, ps);
      hic = st && !dw[0] && in_win(a, dw[4] ? 16'h0170 : 16'h01F0, 8); // R4 R5
      hik = st && !dw[0] && (a == (dw[4] ? 16'h0376 : 16'h03F6));
      hf  = st && !dw[1] && in_win(a, dw[4] ? 16'h0370 : 16'h03F0, 8) && !hik; // R6
      e.sel = {hf, hik, hic, hp && !ha && !hb, hb && !ha, ha};  // R8 R10
      e.cf  = (int'(ha) + int'(hb) + int'(hp)) > 1;
      e.ia  = sa[16]  ? 4'd4 : 4'd0;
      e.ib  = sbp[16] ? 4'd3 : 4'd0;
      e.ip  = pen     ? 4'd7 : 4'd0;
      e.req = req;
      return e;
   endfunction

   // ---------------- driver ----------------
   task automatic apply(input logic [15:0] a, input logic rd, input logic wr,
                        input logic [15:0] pw, input logic [15:0] dw, input int req);
      @(negedge clk);
      io_addr = a; io_rd = rd; io_wr = wr; port_cfg = pw; disk_cfg = dw;
      sb.push_back(model(a, rd | wr, pw, dw, req));
   endtask

   task automatic drain();
      while (sb.size() != 0) @(negedge clk);
   endtask

   function automatic logic [15:0] pword(input int par, input int sa, input int sbc);
      return 16'((par << 9) | (sa << 5) | (sbc << 1));
   endfunction

   // ---------------- monitor ----------------
   always @(posedge clk) begin
      #2;
      if (sb.size() != 0) begin
         exp_t e;
         e = sb.pop_front();
         n_checks++;
         if (sel_o !== e.sel || conflict_o !== e.cf || irq_ser_a_o !== e.ia ||
             irq_ser_b_o !== e.ib || irq_par_o !== e.ip) begin
            n_fail++;
            $display("FAIL R%0d: got sel=%b cf=%b irq=%0d/%0d/%0d, expected sel=%b cf=%b irq=%0d/%0d/%0d",
                     e.req, sel_o, conflict_o, irq_ser_a_o, irq_ser_b_o, irq_par_o,
                     e.sel, e.cf, e.ia, e.ib, e.ip);
         end
      end
   end

   task automatic check_reset(input string when);
      n_checks++;
      if (sel_o !== 6'd0 || conflict_o !== 1'b0 || irq_ser_a_o !== 4'd0 ||
          irq_ser_b_o !== 4'd0 || irq_par_o !== 4'd0) begin
         n_fail++;
         $display("FAIL R9 (%s): got sel=%b cf=%b irq=%0d/%0d/%0d, expected all zero",
                  when, sel_o, conflict_o, irq_ser_a_o, irq_ser_b_o, irq_par_o);
      end
   endtask

   localparam logic [15:0] SER_ADDRS [11] = '{16'h03F8, 16'h03FF, 16'h0400, 16'h02F8, 16'h02FF,
      16'h03E8, 16'h03EF, 16'h02E8, 16'h02EF, 16'h02E7, 16'h13F8};
   localparam logic [15:0] PAR_ADDRS [10] = '{16'h03BC, 16'h03BF, 16'h03C0, 16'h03BB, 16'h0378,
      16'h037F, 16'h0380, 16'h0278, 16'h027F, 16'h1378};
   localparam logic [15:0] DSK_ADDRS [14] = '{16'h01F0, 16'h01F7, 16'h01F8, 16'h0170, 16'h0177,
      16'h03F6, 16'h0376, 16'h03F7, 16'h03F0, 16'h0370, 16'h0377, 16'h03F5, 16'h0375, 16'h03F8};

   initial begin
      // R9: reset holds every output at zero even with a matching access present
      #15 check_reset("during reset");
      @(negedge clk); rst_n = 1'b1;

      // R1: serial B codes and window edges; R11 via 0x13F8
      for (int c = 0; c < 8; c++)
         for (int i = 0; i < 11; i++)
            apply(SER_ADDRS[i], i[0], ~i[0], pword(0, 0, c), 16'h0003, (i == 10) ? 11 : 1);

      // R2: serial A codes and window edges
      for (int c = 0; c < 8; c++)
         for (int i = 0; i < 11; i++)
            apply(SER_ADDRS[i], 1'b1, 1'b0, pword(0, c, 0), 16'h0003, 2);

      // R3: parallel codes, 4-byte window at 0x3BC, 8-byte windows elsewhere
      for (int c = 0; c < 4; c++)
         for (int i = 0; i < 10; i++)
            apply(PAR_ADDRS[i], 1'b0, 1'b1, pword(c, 0, 0), 16'h0003, 3);

      // R4 R5 R6: every enable and base-set combination of the disk word
      for (int d = 0; d < 8; d++)
         for (int i = 0; i < 14; i++)
            apply(DSK_ADDRS[i], 1'b1, 1'b0, 16'h0000,
                  16'(((d >> 2) << 4) | (d & 3)), (d < 4) ? 4 : 5);

      // R6: control byte with IDE on goes to IDE control only, floppy gets it when IDE off
      apply(16'h03F6, 1'b1, 1'b0, 16'h0000, 16'h0000, 6);
      apply(16'h03F6, 1'b1, 1'b0, 16'h0000, 16'h0001, 6);
      apply(16'h0376, 1'b0, 1'b1, 16'h0000, 16'h0011, 6);

      // R7: matching addresses with no strobe select nothing
      apply(16'h03F8, 1'b0, 1'b0, pword(1, 1, 1), 16'h0000, 7);
      apply(16'h01F0, 1'b0, 1'b0, pword(1, 1, 1), 16'h0000, 7);
      apply(16'h03BC, 1'b0, 1'b0, pword(1, 1, 1), 16'h0000, 7);

      // R8: both serial ports on the same base, serial A wins and the flag rises
      for (int c = 1; c < 5; c++) begin
         apply(ser_place(3'(c)) >> 0, 1'b1, 1'b0, pword(2, c, c), 16'h0003, 8);
         apply(16'(ser_place(3'(c))) + 16'd7, 1'b0, 1'b1, pword(2, c, c), 16'h0003, 8);
      end

      // R12: reserved bits set, results must match the clean words
      apply(16'h02F8, 1'b1, 1'b0, pword(3, 0, 2) | 16'hF911, 16'hFFEC, 12);
      apply(16'h0278, 1'b1, 1'b0, pword(3, 0, 2) | 16'hF911, 16'hFFEC, 12);
      apply(16'h03F0, 1'b1, 1'b0, pword(3, 0, 2) | 16'hF911, 16'hFFEC, 12);
      apply(16'h01F0, 1'b1, 1'b0, pword(3, 0, 2) | 16'hF911, 16'hFFEC, 12);

      // R9: latency, a hit followed by an idle cycle
      apply(16'h02E8, 1'b1, 1'b0, pword(0, 4, 0), 16'h0003, 9);
      apply(16'h02E8, 1'b0, 1'b0, pword(0, 4, 0), 16'h0003, 9);
      drain();

      // R9: reset in mid-run clears outputs asynchronously
      @(negedge clk); io_addr = 16'h03F8; io_rd = 1'b1; port_cfg = pword(1, 1, 0);
      @(negedge clk); rst_n = 1'b0;
      #3 check_reset("mid-run reset");
      @(negedge clk); rst_n = 1'b1;
      apply(16'h03F8, 1'b1, 1'b0, pword(1, 1, 0), 16'h0000, 9);
      drain();
      @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule